// File: doc/BRIEF.md
# Zero-Padding Feature Map Row Buffer

This block sits between a byte-wide write port and a four-row processing array. Feature-map bytes are written into four byte-wide RAMs, one per array row. Each RAM is split into two banks, so one bank can be loaded while the other is being read. A run is launched with a start pulse. That pulse latches the layer kind, the per-channel sample count, the edge padding count, the number of concatenated channels per row and the bank to read. The four rows are then read in lockstep.

During a run a sequencer builds each row's byte stream. Convolution layers get zeros at both edges of every channel segment. Deconvolution layers get zeros at both edges plus a zero between every pair of neighbouring samples. Fully connected layers get no padding at all. When a row holds more than one channel, the segments are laid end to end, and each segment is padded on its own. The stream is then closed with zero bytes up to a 4-byte boundary. A per-row deserialiser packs the bytes into 32-bit words for the array.

Top module: `feature_row_buffer`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` in row `wr_row`, bank `wr_bank`, address `wr_addr`. Row r's output stream is read only from row r's RAM.
- R2: Mode 0 (convolution): each channel segment is preceded and followed by `cfg_pad` zero bytes (0 to 7).
- R3: Mode 1 (deconvolution): each segment has `cfg_pad` zeros at each edge. One zero byte sits between every two adjacent samples, so a segment of L samples spans 2*cfg_pad + 2*L - 1 bytes.
- R4: Modes 2 and 3 (fully connected): `cfg_pad` is ignored and no zero byte is inserted, except the closing fill of R6.
- R5: Bytes are packed into 32-bit words in stream order. The first byte goes in bits 7:0 and the fourth in bits 31:24. Each row word appears with its `row_valid` bit high.
- R6: The stream is closed with 0 to 3 zero bytes so that its length is a multiple of 4. The number of words is the padded byte count divided by 4.
- R7: `cfg_segs` (1 or 2) sets how many channels are concatenated per row. Segment s reads addresses s*`cfg_len` to s*`cfg_len`+`cfg_len`-1 of the selected bank. Segment 0 is emitted first.
- R8: A run reads only bank `rd_bank`, which is latched at start. Writes to the other bank during a run do not change that run's output.
- R9: `busy` rises the cycle after an accepted `start`. A `start` pulse while `busy` is high is ignored. `done` is high together with the final word, and `busy` has fallen one cycle earlier.
- R10: After reset, `busy`, `done`, `row_valid` and `row_data` are all zero.
- R11: The four rows are emitted in lockstep: the `row_valid` bits are either all low or all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_row | input | 2 | Row RAM to write |
| wr_bank | input | 1 | Bank to write |
| wr_addr | input | 6 | Byte address within the bank |
| wr_data | input | 8 | Byte to store |
| cfg_mode | input | 2 | 0 convolution, 1 deconvolution, 2/3 fully connected |
| cfg_pad | input | 3 | Zeros at each segment edge |
| cfg_len | input | 6 | Samples per channel segment (at least 1) |
| cfg_segs | input | 2 | Channel segments per row (1 or 2) |
| rd_bank | input | 1 | Bank to read in the run |
| start | input | 1 | Launch a run |
| busy | output | 1 | Sequencer active |
| row_data | output | 128 | Four 32-bit row words, row r in bits 32r+31:32r |
| row_valid | output | 4 | Word valid per row |
| done | output | 1 | Final word of the run |

## Verification
The bench uses the defaults: four rows, 64 bytes per bank, 6-bit length and at most two segments. With these, a 32-sample two-segment row fills a bank completely, and the largest padded deconvolution stream runs to dozens of words. That makes it possible to reach the last address of a bank, a stream that crosses the segment seam, and every residue of the closing fill. The small depth keeps the RAM model in the bench short enough to fill entirely, with a distinct nonzero pattern per bank, row and generation.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;

  localparam logic [1:0] MODE_CONV   = 2'd0;
  localparam logic [1:0] MODE_DECONV = 2'd1;

  function automatic logic is_fc(input logic [1:0] m);
    return m[1];
  endfunction

  // Edge padding actually applied for a mode
  function automatic logic [2:0] eff_pad(input logic [1:0] m, input logic [2:0] p);
    return is_fc(m) ? 3'd0 : p;
  endfunction

  // Bytes in the sample body of one segment
  function automatic int body_len(input logic [1:0] m, input int len);
    return (m == MODE_DECONV) ? (2 * len - 1) : len;
  endfunction

  // Whether body position pos carries a sample (else an inserted zero)
  function automatic logic is_sample(input logic [1:0] m, input int pos);
    return (m != MODE_DECONV) || ((pos % 2) == 0);
  endfunction

  // Sample index within the segment for body position pos
  function automatic int sample_idx(input logic [1:0] m, input int pos);
    return (m == MODE_DECONV) ? (pos / 2) : pos;
  endfunction

endpackage

// File: rtl/rowbuf_ram.sv
module rowbuf_ram #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW:0]   waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW:0]   raddr,
  output logic [7:0]    rdata
);
  localparam int ENTRIES = 2 * (1 << AW);

  logic [7:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rowbuf_pack.sv
module rowbuf_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic [7:0]  in_byte,
  input  logic        in_last,
  output logic [31:0] word,
  output logic        word_vld,
  output logic        word_last
);
  logic [1:0]  lane;
  logic [23:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane      <= 2'd0;
      acc       <= '0;
      word      <= '0;
      word_vld  <= 1'b0;
      word_last <= 1'b0;
    end else begin
      word_vld  <= 1'b0;
      word_last <= 1'b0;
      if (in_vld) begin
        if (lane == 2'd3) begin
          word      <= {in_byte, acc};
          word_vld  <= 1'b1;
          word_last <= in_last;
          lane      <= 2'd0;
        end else begin
          acc[lane*8 +: 8] <= in_byte;
          lane             <= in_last ? 2'd0 : lane + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/rowbuf_seq.sv
module rowbuf_seq
  import rowbuf_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int AW    = 6,
  parameter int SEG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       cfg_mode,
  input  logic [2:0]       cfg_pad,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [SEG_W-1:0] cfg_segs,
  input  logic             rd_bank,
  output logic             busy,
  output logic             emit,
  output logic             emit_zero,
  output logic             emit_last,
  output logic [AW:0]      rd_addr,
  output logic             ev_pad,
  output logic             ev_fill,
  output logic [1:0]       phase_o,
  output logic [1:0]       run_mode_o
);
  localparam int CNTW = LEN_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_BODY, S_TAIL, S_FILL} st_e;

  st_e              st, after_seg;
  logic [CNTW-1:0]  cnt, blen_m1, pad_m1;
  logic [SEG_W-1:0] seg, m_segs;
  logic [AW-1:0]    base, idx;
  logic [1:0]       phase, phase_nx, m_mode;
  logic [2:0]       m_pad, start_pad;
  logic [LEN_W-1:0] m_len;
  logic             m_bank, seg_end, last_seg, smp;

  always_comb begin
    blen_m1   = CNTW'(body_len(m_mode, int'(m_len)) - 1);
    pad_m1    = CNTW'(m_pad) - CNTW'(1);
    smp       = (st == S_BODY) && is_sample(m_mode, int'(cnt));
    idx       = AW'(sample_idx(m_mode, int'(cnt)));
    rd_addr   = {m_bank, base + idx};
    phase_nx  = phase + 2'd1;
    emit      = (st != S_IDLE);
    emit_zero = emit && !smp;
    seg_end   = ((st == S_BODY) && (cnt == blen_m1) && (m_pad == 3'd0)) ||
                ((st == S_TAIL) && (cnt == pad_m1));
    last_seg  = (seg == m_segs - SEG_W'(1));
    emit_last = (seg_end && last_seg && (phase_nx == 2'd0)) ||
                ((st == S_FILL) && (phase_nx == 2'd0));
    if (last_seg)
      after_seg = (phase_nx == 2'd0) ? S_IDLE : S_FILL;
    else
      after_seg = (m_pad != 3'd0) ? S_LEAD : S_BODY;
    start_pad  = eff_pad(cfg_mode, cfg_pad);
    busy       = emit;
    ev_pad     = (st == S_LEAD) || (st == S_TAIL);
    ev_fill    = (st == S_FILL);
    phase_o    = phase;
    run_mode_o = m_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      seg    <= '0;
      base   <= '0;
      phase  <= 2'd0;
      m_mode <= MODE_CONV;
      m_pad  <= 3'd0;
      m_len  <= '0;
      m_segs <= SEG_W'(1);
      m_bank <= 1'b0;
    end else begin
      if (emit) phase <= phase_nx;
      case (st)
        S_IDLE: if (start) begin
          m_mode <= cfg_mode;
          m_pad  <= start_pad;
          m_len  <= (cfg_len == '0) ? LEN_W'(1) : cfg_len;
          m_segs <= (cfg_segs == '0) ? SEG_W'(1) : cfg_segs;
          m_bank <= rd_bank;
          seg    <= '0;
          base   <= '0;
          cnt    <= '0;
          phase  <= 2'd0;
          st     <= (start_pad != 3'd0) ? S_LEAD : S_BODY;
        end
        S_LEAD: begin
          if (cnt == pad_m1) begin
            cnt <= '0;
            st  <= S_BODY;
          end else cnt <= cnt + CNTW'(1);
        end
        S_BODY, S_TAIL: begin
          if (seg_end) begin
            cnt <= '0;
            st  <= after_seg;
            if (!last_seg) begin
              seg  <= seg + SEG_W'(1);
              base <= base + AW'(m_len);
            end
          end else if ((st == S_BODY) && (cnt == blen_m1)) begin
            cnt <= '0;
            st  <= S_TAIL;
          end else cnt <= cnt + CNTW'(1);
        end
        S_FILL: if (phase_nx == 2'd0) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/feature_row_buffer.sv
module feature_row_buffer
  import rowbuf_pkg::*;
#(
  parameter int ROWS    = 4,
  parameter int DEPTH   = 64,
  parameter int LEN_W   = 6,
  parameter int SEG_MAX = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [$clog2(ROWS)-1:0] wr_row,
  input  logic                  wr_bank,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [1:0]            cfg_mode,
  input  logic [2:0]            cfg_pad,
  input  logic [LEN_W-1:0]      cfg_len,
  input  logic [$clog2(SEG_MAX+1)-1:0] cfg_segs,
  input  logic                  rd_bank,
  input  logic                  start,
  output logic                  busy,
  output logic [ROWS*32-1:0]    row_data,
  output logic [ROWS-1:0]       row_valid,
  output logic                  done
);
  localparam int AW    = $clog2(DEPTH);
  localparam int RW    = $clog2(ROWS);
  localparam int SEG_W = $clog2(SEG_MAX + 1);

  logic          emit, emit_zero, emit_last;
  logic [AW:0]   rd_addr;
  logic          ev_pad, ev_fill;
  logic [1:0]    seq_phase, run_mode;
  logic          b_vld, b_zero, b_last;
  logic [ROWS-1:0] w_last;

  rowbuf_seq #(.LEN_W(LEN_W), .AW(AW), .SEG_W(SEG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_mode(cfg_mode), .cfg_pad(cfg_pad), .cfg_len(cfg_len),
    .cfg_segs(cfg_segs), .rd_bank(rd_bank),
    .busy(busy), .emit(emit), .emit_zero(emit_zero), .emit_last(emit_last),
    .rd_addr(rd_addr), .ev_pad(ev_pad), .ev_fill(ev_fill),
    .phase_o(seq_phase), .run_mode_o(run_mode)
  );

  // Byte stage flags aligned with the RAM read data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_vld  <= 1'b0;
      b_zero <= 1'b0;
      b_last <= 1'b0;
    end else begin
      b_vld  <= emit;
      b_zero <= emit_zero;
      b_last <= emit_last;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [7:0]  q, byte_v;
    logic [31:0] word;
    logic        vld;

    rowbuf_ram #(.AW(AW)) u_ram (
      .clk(clk),
      .we(wr_en && (wr_row == RW'(r))),
      .waddr({wr_bank, wr_addr}),
      .wdata(wr_data),
      .re(emit),
      .raddr(rd_addr),
      .rdata(q)
    );

    assign byte_v = b_zero ? 8'h00 : q;

    rowbuf_pack u_pack (
      .clk(clk), .rst_n(rst_n),
      .in_vld(b_vld), .in_byte(byte_v), .in_last(b_last),
      .word(word), .word_vld(vld), .word_last(w_last[r])
    );

    assign row_data[r*32 +: 32] = word;
    assign row_valid[r]         = vld;
  end

  assign done = &(row_valid & w_last);

endmodule

// File: rtl/rowbuf_chk.sv
module rowbuf_chk #(
  parameter int ROWS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic [ROWS-1:0] row_valid,
  input logic            done,
  input logic            ev_pad,
  input logic            ev_fill,
  input logic [1:0]      fill_phase,
  input logic [1:0]      run_mode
);
  // R11
  rows_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(row_valid) == 0) || ($countones(row_valid) == ROWS));

  // R4
  fc_no_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pad |-> !run_mode[1]);

  // R6
  fill_unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |-> (fill_phase != 2'd0));

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R9
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> done);

  // R9
  pad_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pad || ev_fill) |-> busy);
endmodule

bind feature_row_buffer rowbuf_chk #(.ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .row_valid(row_valid), .done(done), .ev_pad(ev_pad), .ev_fill(ev_fill),
  .fill_phase(seq_phase), .run_mode(run_mode)
);

// File: tb/feature_row_buffer_tb.sv
module feature_row_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_row = '0;
  logic        wr_bank = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  cfg_mode = '0;
  logic [2:0]  cfg_pad = '0;
  logic [5:0]  cfg_len = '0;
  logic [1:0]  cfg_segs = '0;
  logic        rd_bank = 1'b0;
  logic        start = 1'b0;
  logic        busy, done;
  logic [127:0] row_data;
  logic [3:0]  row_valid;

  int tests = 0, fails = 0;

  feature_row_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_mode(cfg_mode), .cfg_pad(cfg_pad), .cfg_len(cfg_len),
    .cfg_segs(cfg_segs), .rd_bank(rd_bank), .start(start),
    .busy(busy), .row_data(row_data), .row_valid(row_valid), .done(done)
  );

  always #4 clk = ~clk;

  logic [7:0]  mem  [2][4][64];
  logic [7:0]  expb [4][256];
  logic [31:0] got  [4][64];
  int cap_n, exp_n, lock_err;
  bit done_seen;

  // mode, pad, len, segs, bank
  localparam int NV = 9;
  localparam int VEC [NV][5] = '{
    '{0, 2,  8, 1, 0}, '{0, 0,  5, 1, 1}, '{1, 1,  4, 1, 0},
    '{1, 3,  6, 2, 1}, '{2, 5,  7, 1, 0}, '{3, 0, 16, 2, 1},
    '{0, 7, 32, 2, 0}, '{1, 0,  1, 1, 0}, '{0, 1,  1, 2, 1}
  };

  always @(negedge clk) begin
    if (row_valid != 4'h0 && row_valid != 4'hF) lock_err++;
    if (row_valid[0] && cap_n < 64) begin
      for (int r = 0; r < 4; r++) got[r][cap_n] = row_data[r*32 +: 32];
      cap_n++;
    end
    if (done) done_seen = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int b, int r, int a, int gen);
    return 8'(((a * 7 + r * 61 + b * 29 + gen * 13) % 255) + 1);
  endfunction

  // R1: bytes go to the addressed row and bank
  task automatic load_bank(input int b, input int gen);
    for (int r = 0; r < 4; r++)
      for (int a = 0; a < 64; a++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_row = 2'(r); wr_bank = 1'(b);
        wr_addr = 6'(a); wr_data = pat(b, r, a, gen);
        mem[b][r][a] = wr_data;
      end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic build_exp(input int mode, input int pad, input int len,
                           input int segs, input int b);
    int ep;
    ep = (mode >= 2) ? 0 : pad;
    for (int r = 0; r < 4; r++) begin
      int n;
      n = 0;
      for (int s = 0; s < segs; s++) begin
        for (int k = 0; k < ep; k++) expb[r][n++] = 8'h00;
        for (int i = 0; i < len; i++) begin
          if (mode == 1 && i > 0) expb[r][n++] = 8'h00;
          expb[r][n++] = mem[b][r][s * len + i];
        end
        for (int k = 0; k < ep; k++) expb[r][n++] = 8'h00;
      end
      while (n % 4 != 0) expb[r][n++] = 8'h00;
      exp_n = n;
    end
  endtask

  // extra: 0 none, 1 competing start mid-run, 2 write other bank mid-run
  task automatic run_case(input int mode, input int pad, input int len,
                          input int segs, input int b, input int extra);
    string tag;
    build_exp(mode, pad, len, segs, b);
    tag = (mode == 0) ? "R2" : (mode == 1) ? "R3" : "R4";
    if (segs == 2) tag = {tag, "/R7"};
    if (extra == 2) tag = {tag, "/R8"};
    @(negedge clk);
    cap_n = 0; done_seen = 1'b0; lock_err = 0;
    cfg_mode = 2'(mode); cfg_pad = 3'(pad); cfg_len = 6'(len);
    cfg_segs = 2'(segs); rd_bank = 1'(b); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    if (extra == 1) begin
      repeat (3) @(negedge clk);
      cfg_mode = 2'd2; cfg_pad = 3'd0; cfg_len = 6'd3; cfg_segs = 2'd1;
      rd_bank = 1'(1 - b); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      tag = {tag, "/R9"};
    end
    if (extra == 2) begin
      for (int a = 0; a < 4; a++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_row = 2'(a); wr_bank = 1'(1 - b);
        wr_addr = 6'(a); wr_data = 8'hEE;
        mem[1 - b][a][a] = 8'hEE;
      end
      @(negedge clk);
      wr_en = 1'b0;
    end
    while (!done_seen) @(negedge clk);
    // R6: word count is padded length / 4
    check(cap_n == exp_n / 4, {"R6 word count ", tag}, cap_n, exp_n / 4);
    // R11: rows lockstep
    check(lock_err == 0, "R11 lockstep", lock_err, 0);
    for (int r = 0; r < 4; r++) begin
      int bad;
      logic [31:0] ew, aw;
      bad = 0; ew = '0; aw = '0;
      for (int w = 0; w < exp_n / 4 && w < cap_n; w++) begin
        // R5: first byte in bits 7:0
        logic [31:0] e;
        e = {expb[r][4*w+3], expb[r][4*w+2], expb[r][4*w+1], expb[r][4*w]};
        if (got[r][w] !== e && bad == 0) begin
          bad = 1; ew = e; aw = got[r][w];
        end
      end
      check(bad == 0, {"R1/R5 content ", tag}, aw, ew);
    end
    @(negedge clk);
    check(busy == 1'b0, "R9 idle after run", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cap_n = 0; done_seen = 1'b0; lock_err = 0; exp_n = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy == 1'b0 && done == 1'b0, "R10 busy/done", {busy, done}, 0);
    check(row_valid == 4'h0, "R10 row_valid", row_valid, 0);
    check(row_data == '0, "R10 row_data", row_data[63:0], 0);
    rst_n = 1'b1;
    load_bank(0, 0);
    load_bank(1, 0);
    for (int v = 0; v < NV; v++)
      run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 0);
    // R9: a start during a run is ignored
    run_case(0, 7, 32, 2, 0, 1);
    // R8: bank 1 written while bank 0 is read, then bank 1 read back
    run_case(1, 2, 10, 2, 0, 2);
    run_case(2, 0, 4, 1, 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule